// File: doc/BRIEF.md
# External Bus Strobe Generator

This block paces the external memory bus of an 8-bit controller core from the raw oscillator clock. It splits every machine cycle into twelve oscillator periods, raises the address latch strobe twice per cycle and lowers the program read strobe twice per cycle whenever the cycle fetches code from off-chip. It also picks which byte drives the high address port: either the upper half of an address or the value held in that port's output latch.

At the last phase of each machine cycle the block samples the core's request lines: the fetch address, the external-access pin, a data-transfer flag, a wide/narrow data address select, the latch-strobe quiet bit, the port latch and the upper data address byte. These values settle one of four cycle kinds for the twelve phases that follow. Data-transfer cycles drop the second latch pulse and both read pulses. When the quiet bit is set, the latch strobe is held low in cycles that make no use of the bus.

Top module: `xbus_strobe_gen`

## Requirements
- R1: `mc_phase` counts 0 to 11 and wraps. `ale` is high exactly at phases 0, 1, 6 and 7 of a cycle in which nothing suppresses it, so a plain cycle holds two pulses of two periods each.
- R2: While `rst` is high at a rising edge, the next outputs are `ale`=0, `psen_n`=1, `port2_out`=8'hFF, `port2_addr_mode`=0 and `mc_phase`=0.
- R3: In a data-transfer cycle (`movx_cycle`=1 at capture) `ale` pulses at phases 0 and 1 only. The pulse at phases 6 and 7 is skipped.
- R4: In an external fetch cycle `psen_n` is low exactly at phases 3, 4, 5, 9, 10 and 11. It is never low while `ale` is high.
- R5: In a data-transfer cycle `psen_n` stays high for all twelve phases.
- R6: In an internal fetch cycle `psen_n` stays high for all twelve phases.
- R7: A non-transfer cycle is an external fetch when `ext_access_pin`=0, or when `fetch_pc` > 16'h0FFF. Otherwise it is internal, so 0FFF stays internal and 1000 goes external when the pin is high.
- R8: With `ale_quiet`=1 at capture, `ale` stays low for a whole internal fetch cycle. External fetch and data-transfer cycles still pulse as in R1 and R3.
- R9: `port2_out` carries `fetch_pc[15:8]` in an external fetch cycle and `data_addr_hi` in a wide data cycle, with `port2_addr_mode`=1 in both. It carries `p2_latch` in a narrow data cycle and in an internal fetch cycle, with `port2_addr_mode`=0.
- R10: Inputs are sampled only at the rising edge where `mc_phase` is 11. Input changes at other phases leave the outputs of the current cycle unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_access_pin | input | 1 | 1: low code space is on-chip; 0: every fetch is off-chip |
| fetch_pc | input | 16 | Address of the code fetch for the next cycle |
| movx_cycle | input | 1 | Next cycle is an external data transfer |
| movx_wide | input | 1 | 1: data transfer uses a 16-bit address; 0: an 8-bit address |
| ale_quiet | input | 1 | Register bit that suppresses the latch strobe in cycles that do not use the bus |
| p2_latch | input | 8 | Contents of the high port output latch |
| data_addr_hi | input | 8 | Upper byte of the data transfer address |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program read strobe, active low |
| port2_out | output | 8 | Byte driven on the high address port |
| port2_addr_mode | output | 1 | High when the port carries an address byte |
| mc_phase | output | 4 | Current phase within the machine cycle |

## Verification
Two functions can fall in the same cycle. A data transfer can be requested while the fetch address also points off-chip, and the quiet bit can be set in the same cycle as either of them. The bench sets these combinations at once, for example a transfer with the external-access pin low and quiet set, and expects the transfer to win: one latch pulse, no read pulses and the data byte on the port. It also changes the request lines halfway through a cycle and checks, on every clock against its own phase-by-phase model, that the running cycle keeps its shape and that the new request takes effect only from the next cycle.

// File: rtl/xbus_strobe_pkg.sv
package xbus_strobe_pkg;

    localparam int BYTE_W = 8;

    // Kind of machine cycle, settled once per cycle at the last phase.
    typedef enum logic [1:0] {
        CYC_INT_FETCH   = 2'd0,
        CYC_EXT_FETCH   = 2'd1,
        CYC_DATA_WIDE   = 2'd2,
        CYC_DATA_NARROW = 2'd3
    } cyc_kind_e;

    // Everything the strobe shaper needs for one machine cycle.
    typedef struct packed {
        cyc_kind_e          kind;
        logic [BYTE_W-1:0]  hi_byte;
        logic               ale_quiet;
    } cyc_ctx_t;

    localparam cyc_ctx_t CTX_RESET = '{
        kind:      CYC_INT_FETCH,
        hi_byte:   {BYTE_W{1'b1}},
        ale_quiet: 1'b0
    };

    function automatic logic kind_is_data(cyc_kind_e k);
        return (k == CYC_DATA_WIDE) || (k == CYC_DATA_NARROW);
    endfunction

    function automatic logic kind_drives_addr(cyc_kind_e k);
        return (k == CYC_EXT_FETCH) || (k == CYC_DATA_WIDE);
    endfunction

    // True when ph lies in [lo, lo+len).
    function automatic logic in_window(int ph, int lo, int len);
        return (ph >= lo) && (ph < lo + len);
    endfunction

endpackage

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr #(
    parameter int PHASES = 12,
    parameter int PH_W   = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase_q,
    output logic [PH_W-1:0] phase_d,
    output logic            last_phase
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

    assign last_phase = (phase_q == PH_LAST);
    assign phase_d    = last_phase ? '0 : phase_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

endmodule

// File: rtl/xbus_cycle_ctx.sv
module xbus_cycle_ctx
    import xbus_strobe_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] INT_LIMIT = 16'h0FFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              ext_access_pin,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              movx_cycle,
    input  logic              movx_wide,
    input  logic              ale_quiet,
    input  logic [BYTE_W-1:0] p2_latch,
    input  logic [BYTE_W-1:0] data_addr_hi,
    output cyc_ctx_t          ctx_d
);

    cyc_ctx_t ctx_q;
    cyc_ctx_t ctx_new;
    logic     fetch_off_chip;

    // Pin low sends every fetch off-chip; pin high only above the on-chip limit.
    assign fetch_off_chip = !ext_access_pin || (fetch_pc > INT_LIMIT);

    always_comb begin
        ctx_new.ale_quiet = ale_quiet;
        if (movx_cycle) begin
            if (movx_wide) begin
                ctx_new.kind    = CYC_DATA_WIDE;
                ctx_new.hi_byte = data_addr_hi;
            end else begin
                ctx_new.kind    = CYC_DATA_NARROW;
                ctx_new.hi_byte = p2_latch;
            end
        end else if (fetch_off_chip) begin
            ctx_new.kind    = CYC_EXT_FETCH;
            ctx_new.hi_byte = fetch_pc[ADDR_W-1 -: BYTE_W];
        end else begin
            ctx_new.kind    = CYC_INT_FETCH;
            ctx_new.hi_byte = p2_latch;
        end
    end

    assign ctx_d = capture ? ctx_new : ctx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= CTX_RESET;
        end else begin
            ctx_q <= ctx_d;
        end
    end

endmodule

// File: rtl/xbus_strobe_out.sv
module xbus_strobe_out
    import xbus_strobe_pkg::*;
#(
    parameter int PHASES = 12,
    parameter int ALE_W  = 2,
    parameter int PSEN_W = 3,
    parameter int PH_W   = $clog2(PHASES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PH_W-1:0]   phase_d,
    input  cyc_ctx_t          ctx_d,
    output logic              ale,
    output logic              psen_n,
    output logic [BYTE_W-1:0] port2_out,
    output logic              port2_addr_mode
);

    localparam int HALF = PHASES / 2;

    logic [1:0] ale_hit;
    logic [1:0] ale_keep;
    logic [1:0] psen_hit;
    logic       ale_enable;
    logic       ale_nxt;
    logic       psen_nxt;

    // One latch window at the start and one read window at the end of each half.
    for (genvar h = 0; h < 2; h++) begin : g_half
        localparam int ALE_LO  = h * HALF;
        localparam int PSEN_LO = h * HALF + HALF - PSEN_W;

        assign ale_hit[h]  = in_window(int'(phase_d), ALE_LO, ALE_W);
        assign psen_hit[h] = in_window(int'(phase_d), PSEN_LO, PSEN_W);

        if (h == 0) begin : g_first
            assign ale_keep[h] = 1'b1;
        end else begin : g_second
            assign ale_keep[h] = !kind_is_data(ctx_d.kind);
        end
    end

    assign ale_enable = !(ctx_d.ale_quiet && (ctx_d.kind == CYC_INT_FETCH));
    assign ale_nxt    = ale_enable && |(ale_hit & ale_keep);
    assign psen_nxt   = (ctx_d.kind == CYC_EXT_FETCH) && |psen_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ale             <= 1'b0;
            psen_n          <= 1'b1;
            port2_out       <= '1;
            port2_addr_mode <= 1'b0;
        end else begin
            ale             <= ale_nxt;
            psen_n          <= !psen_nxt;
            port2_out       <= ctx_d.hi_byte;
            port2_addr_mode <= kind_drives_addr(ctx_d.kind);
        end
    end

endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
    import xbus_strobe_pkg::*;
#(
    parameter int                PHASES    = 12,
    parameter int                ADDR_W    = 16,
    parameter int                ALE_W     = 2,
    parameter int                PSEN_W    = 3,
    parameter logic [ADDR_W-1:0] INT_LIMIT = 16'h0FFF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ext_access_pin,
    input  logic [ADDR_W-1:0]          fetch_pc,
    input  logic                       movx_cycle,
    input  logic                       movx_wide,
    input  logic                       ale_quiet,
    input  logic [7:0]                 p2_latch,
    input  logic [7:0]                 data_addr_hi,
    output logic                       ale,
    output logic                       psen_n,
    output logic [7:0]                 port2_out,
    output logic                       port2_addr_mode,
    output logic [$clog2(PHASES)-1:0]  mc_phase
);

    localparam int PH_W = $clog2(PHASES);

    logic [PH_W-1:0] phase_d;
    logic            last_phase;
    cyc_ctx_t        ctx_d;

    xbus_phase_ctr #(
        .PHASES (PHASES),
        .PH_W   (PH_W)
    ) u_phase (
        .clk        (clk),
        .rst        (rst),
        .phase_q    (mc_phase),
        .phase_d    (phase_d),
        .last_phase (last_phase)
    );

    xbus_cycle_ctx #(
        .ADDR_W    (ADDR_W),
        .INT_LIMIT (INT_LIMIT)
    ) u_ctx (
        .clk            (clk),
        .rst            (rst),
        .capture        (last_phase),
        .ext_access_pin (ext_access_pin),
        .fetch_pc       (fetch_pc),
        .movx_cycle     (movx_cycle),
        .movx_wide      (movx_wide),
        .ale_quiet      (ale_quiet),
        .p2_latch       (p2_latch),
        .data_addr_hi   (data_addr_hi),
        .ctx_d          (ctx_d)
    );

    xbus_strobe_out #(
        .PHASES (PHASES),
        .ALE_W  (ALE_W),
        .PSEN_W (PSEN_W),
        .PH_W   (PH_W)
    ) u_out (
        .clk             (clk),
        .rst             (rst),
        .phase_d         (phase_d),
        .ctx_d           (ctx_d),
        .ale             (ale),
        .psen_n          (psen_n),
        .port2_out       (port2_out),
        .port2_addr_mode (port2_addr_mode)
    );

endmodule

// File: rtl/xbus_strobe_chk.sv
module xbus_strobe_chk #(
    parameter int PHASES = 12,
    parameter int ALE_W  = 2,
    parameter int PSEN_W = 3,
    parameter int PH_W   = $clog2(PHASES)
) (
    input logic            clk,
    input logic            rst,
    input logic            ale,
    input logic            psen_n,
    input logic [7:0]      port2_out,
    input logic            port2_addr_mode,
    input logic [PH_W-1:0] mc_phase
);

    localparam int HALF = PHASES / 2;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!ale && psen_n && (port2_out == 8'hFF) && !port2_addr_mode)); // R2

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (mc_phase == PH_LAST) |=> (mc_phase == '0)); // R1

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (mc_phase != PH_LAST) |=> (mc_phase == $past(mc_phase) + 1'b1)); // R1

    AST_ALE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        ale |-> ((int'(mc_phase) % HALF) < ALE_W)); // R1

    AST_PSEN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        !psen_n |-> ((int'(mc_phase) % HALF) >= HALF - PSEN_W)); // R4

    AST_PSEN_NEEDS_ADDR: assert property (@(posedge clk) disable iff (rst)
        !psen_n |-> port2_addr_mode); // R4

    AST_NO_STROBE_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(ale && !psen_n)); // R4

    AST_PORT_HELD: assert property (@(posedge clk) disable iff (rst)
        (mc_phase != '0) |-> ($stable(port2_out) && $stable(port2_addr_mode))); // R10

endmodule

bind xbus_strobe_gen xbus_strobe_chk #(
    .PHASES (PHASES),
    .ALE_W  (ALE_W),
    .PSEN_W (PSEN_W)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .ale             (ale),
    .psen_n          (psen_n),
    .port2_out       (port2_out),
    .port2_addr_mode (port2_addr_mode),
    .mc_phase        (mc_phase)
);

// File: tb/xbus_strobe_gen_test.sv
module xbus_strobe_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_access_pin = 1'b1;
    logic [15:0] fetch_pc = 16'h0000;
    logic        movx_cycle = 1'b0;
    logic        movx_wide = 1'b0;
    logic        ale_quiet = 1'b0;
    logic [7:0]  p2_latch = 8'h00;
    logic [7:0]  data_addr_hi = 8'h00;
    logic        ale;
    logic        psen_n;
    logic [7:0]  port2_out;
    logic        port2_addr_mode;
    logic [3:0]  mc_phase;

    always #10 clk = ~clk;

    xbus_strobe_gen uut (
        .clk             (clk),
        .rst             (rst),
        .ext_access_pin  (ext_access_pin),
        .fetch_pc        (fetch_pc),
        .movx_cycle      (movx_cycle),
        .movx_wide       (movx_wide),
        .ale_quiet       (ale_quiet),
        .p2_latch        (p2_latch),
        .data_addr_hi    (data_addr_hi),
        .ale             (ale),
        .psen_n          (psen_n),
        .port2_out       (port2_out),
        .port2_addr_mode (port2_addr_mode),
        .mc_phase        (mc_phase)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: kind 0 internal fetch, 1 external fetch,
    // 2 wide data transfer, 3 narrow data transfer.
    int m_ph = 0;
    int m_kind = 0;
    int m_hi = 255;
    bit m_quiet = 0;
    bit m_in_rst = 1;
    bit m_started = 0;

    always @(posedge clk) begin
        m_started = 1;
        if (rst) begin
            m_ph = 0; m_kind = 0; m_hi = 255; m_quiet = 0; m_in_rst = 1;
        end else begin
            m_in_rst = 0;
            if (m_ph == 11) begin
                m_quiet = ale_quiet;
                if (movx_cycle) begin
                    m_kind = movx_wide ? 2 : 3;
                    m_hi   = movx_wide ? int'(data_addr_hi) : int'(p2_latch);
                end else if (!ext_access_pin || fetch_pc >= 16'h1000) begin
                    m_kind = 1; m_hi = int'(fetch_pc[15:8]);
                end else begin
                    m_kind = 0; m_hi = int'(p2_latch);
                end
            end
            m_ph = (m_ph + 1) % 12;
        end
    end

    always @(negedge clk) begin
        if (m_started && !finished) begin
            int e_ale, e_psen_n, e_mode, slot;
            if (m_in_rst) begin
                check("R2 ale", int'(ale), 0);
                check("R2 psen_n", int'(psen_n), 1);
                check("R2 port2_out", int'(port2_out), 255);
                check("R2 port2_addr_mode", int'(port2_addr_mode), 0);
                check("R2 mc_phase", int'(mc_phase), 0);
            end else begin
                slot = m_ph % 6;
                e_ale = (slot < 2) ? 1 : 0;
                if ((m_kind >= 2) && (m_ph >= 6)) e_ale = 0;
                if (m_quiet && m_kind == 0) e_ale = 0;
                e_psen_n = (m_kind == 1 && slot >= 3) ? 0 : 1;
                e_mode = (m_kind == 1 || m_kind == 2) ? 1 : 0;
                check("R1 mc_phase", int'(mc_phase), m_ph);
                check("R1 R3 R8 ale", int'(ale), e_ale);
                check("R4 R5 R6 R7 psen_n", int'(psen_n), e_psen_n);
                check("R9 R10 port2_out", int'(port2_out), m_hi);
                check("R9 port2_addr_mode", int'(port2_addr_mode), e_mode);
            end
        end
    end

    task automatic set_req(bit pin, logic [15:0] pc, bit mx, bit wide,
                           bit quiet, logic [7:0] p2, logic [7:0] dhi);
        @(negedge clk);
        ext_access_pin = pin; fetch_pc = pc; movx_cycle = mx; movx_wide = wide;
        ale_quiet = quiet; p2_latch = p2; data_addr_hi = dhi;
    endtask

    // Counts strobe activity over the cycle that uses the current inputs.
    task automatic observe(string tag, int exp_ale, int exp_psen, bit upset);
        int n_ale = 0;
        int n_psen = 0;
        do @(negedge clk); while (mc_phase != 4'd11);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (ale) n_ale++;
            if (!psen_n) n_psen++;
            if (upset && i == 4) begin
                movx_cycle = 1'b1; movx_wide = 1'b1; ale_quiet = 1'b1;
                ext_access_pin = 1'b1; fetch_pc = 16'h0001; p2_latch = 8'h77;
            end
        end
        check({tag, " ale periods"}, n_ale, exp_ale);
        check({tag, " psen periods"}, n_psen, exp_psen);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R6 internal fetch, plain double latch pulse (R1)
        set_req(1, 16'h0100, 0, 0, 0, 8'h5A, 8'h00);
        observe("R1 R6 internal", 4, 0, 0);
        // R7 boundary: 0FFF internal, 1000 external
        set_req(1, 16'h0FFF, 0, 0, 0, 8'h11, 8'h00);
        observe("R7 limit 0FFF", 4, 0, 0);
        set_req(1, 16'h1000, 0, 0, 0, 8'h11, 8'h00);
        observe("R7 R4 above 0FFF", 4, 6, 0);
        set_req(0, 16'h0010, 0, 0, 0, 8'h22, 8'h00);
        observe("R7 pin low", 4, 6, 0);
        // R3 R5 data transfers, wide and narrow (R9 checked per clock)
        set_req(0, 16'h8000, 1, 1, 0, 8'h3C, 8'hA5);
        observe("R3 R5 wide data", 2, 0, 0);
        set_req(1, 16'h0200, 1, 0, 0, 8'h3C, 8'hA5);
        observe("R3 R5 narrow data", 2, 0, 0);
        // R8 quiet bit
        set_req(1, 16'h0300, 0, 0, 1, 8'h44, 8'h00);
        observe("R8 quiet internal", 0, 0, 0);
        set_req(1, 16'hC000, 0, 0, 1, 8'h44, 8'h00);
        observe("R8 quiet external", 4, 6, 0);
        set_req(0, 16'hC000, 1, 0, 1, 8'h44, 8'h00);
        observe("R8 quiet data", 2, 0, 0);
        // R10 mid-cycle change must not reshape the running cycle
        set_req(0, 16'h2000, 0, 0, 0, 8'h00, 8'h00);
        observe("R10 upset", 4, 6, 1);
        observe("R10 next cycle", 2, 0, 0);
        // R2 reset in mid-cycle
        repeat (5) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // mixed traffic, compared per clock
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (($urandom % 5) == 0) begin
                ext_access_pin = 1'($urandom);
                fetch_pc = 16'($urandom);
                movx_cycle = (($urandom % 3) == 0);
                movx_wide = 1'($urandom);
                ale_quiet = 1'($urandom);
                p2_latch = 8'($urandom);
                data_addr_hi = 8'($urandom);
            end
        end
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule